// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Retry

This block sends one byte at a time over the single open-drain data line of an asynchronous half-duplex smart card link. An accepted byte becomes a character frame: a low start bit, eight data bits in the selected order, an even parity bit, and a guard period in which the line is released. All bit boundaries are set by an external tick that pulses once per elementary time unit (etu).

During the guard period the receiver may hold the line low to reject the character. In the byte-oriented protocol mode the block then resends the character on its own, up to a programmed number of times. In the block-oriented protocol mode a rejection is reported but never retried. In the plain mode the guard level is ignored. When the character is finished the block gives a one-cycle done pulse. If the last attempt was still rejected, a sticky error flag is raised.

The line is only ever pulled low. A logic 1 is sent by releasing the line to its external pull-up. The sampled line level comes back on `io_in` and passes through a synchroniser.

Top module: `sc_char_tx`

## Requirements
- R1: `tx_ready` is high only when no character is in progress and `mode` is not 2'b11. `tx_valid` has no effect while `tx_ready` is low. The byte, `mode`, `retry_limit` and `msb_first` are captured when a byte is accepted, and later changes to them do not alter the character in progress.
- R2: One attempt lasts 12 etus. The first etu is the start bit, with the line driven low. The next eight etus carry the data bits. The tenth etu carries the parity bit, chosen so that the nine data and parity bits hold an even number of ones. The last two etus form the guard period, with the line released. A 0 bit drives the line low and a 1 bit releases it. Each `etu_tick` pulse ends the current etu, and the start bit begins on the clock edge that accepts the byte.
- R3: With `msb_first` = 1 data bit 7 is sent first. With `msb_first` = 0 data bit 0 is sent first.
- R4: The line is sampled at the tick that ends the first guard etu. A low level there is a NACK. A NACK is recognised in mode 2'b01 (byte protocol) and mode 2'b10 (block protocol). In mode 2'b00 (plain) the guard level is ignored.
- R5: In mode 2'b01, a NACK while retries remain starts the start bit of a new attempt of the same byte on the edge that ends the guard period. At most `retry_limit` such resends happen, and an attempt without a NACK ends the character.
- R6: With `retry_limit` = 0 a character is sent once, even when it draws a NACK.
- R7: In mode 2'b10 a character is sent once, whatever `retry_limit` holds.
- R8: `done` is high for exactly the one cycle after the edge that ends the last attempt's guard period. `err_flag` is set on that same edge if the last attempt drew a NACK. It then stays set until the next byte is accepted, which clears it.
- R9: After reset the line is released, `done` and `err_flag` are low, and `tx_ready` is high for a mode other than 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Byte offered for sending |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block can accept a byte |
| mode | input | 2 | 00 plain, 01 byte protocol, 10 block protocol, 11 reserved |
| retry_limit | input | 3 | Maximum resends after a NACK (byte protocol only) |
| msb_first | input | 1 | 1 sends bit 7 first, 0 sends bit 0 first |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| io_in | input | 1 | Sampled level of the data line |
| io_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| done | output | 1 | One-cycle pulse when a character is finished |
| err_flag | output | 1 | Sticky: last character ended on a NACK |

## Verification
The bench drives sequences of NACKs that stop one attempt before the retries run out, that land exactly on the limit, and that continue past it, including the largest limit of seven. A design with an off-by-one in its retry count would send one frame too many or too few and move the done pulse by a whole frame. Block-protocol and plain-mode cases with a NACK present catch a design that retries or flags an error where the mode forbids it. Changing the configuration and offering a second byte in the middle of a character catches a design that reads live settings or accepts while busy, because the frame bit pattern would then differ. Both bit orders and an all-zero byte expose parity or order mistakes. The error flag is checked for stickiness before the next accept and for clearing after it.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_BYTE  = 2'b01,
    MODE_BLOCK = 2'b10,
    MODE_RSVD  = 2'b11
  } sc_mode_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_START,
    F_DATA,
    F_PAR,
    F_GUARD
  } frm_state_e;

endpackage

// File: rtl/sc_tx_sync.sv
module sc_tx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sc_tx_frame.sv
module sc_tx_frame
  import sc_tx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int GUARD_ETU = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 etu_tick,
  input  logic                 start,
  input  logic [DATA_BITS-1:0] start_data,
  input  logic                 start_msb,
  input  logic                 start_chk,
  input  logic                 line_in,
  output logic                 line_drive_low,
  output logic                 frame_idle,
  output logic                 attempt_end,
  output logic                 nack
);

  localparam int CNT_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int GCNT_W = $clog2(GUARD_ETU);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_BITS - 1);
  localparam logic [GCNT_W-1:0] SAMP_AT  = GCNT_W'(GUARD_ETU / 2 - 1);
  localparam logic [GCNT_W-1:0] GRD_LAST = GCNT_W'(GUARD_ETU - 1);

  frm_state_e           state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [GCNT_W-1:0]    gcnt_q, gcnt_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 par_q, par_d;
  logic                 chk_q, chk_d;
  logic                 nack_q, nack_d;
  logic [DATA_BITS-1:0] data_rev;
  logic                 guard_done;
  logic                 load;
  logic                 en;

  // bit-reversed copy so the shifter always sends its bit 0 next
  generate
    for (genvar gi = 0; gi < DATA_BITS; gi++) begin : g_rev
      assign data_rev[gi] = start_data[DATA_BITS-1-gi];
    end
  endgenerate

  assign guard_done  = (state_q == F_GUARD) && etu_tick && (gcnt_q == GRD_LAST);
  assign attempt_end = guard_done;
  assign load        = start && ((state_q == F_IDLE) || guard_done);
  assign en          = etu_tick | load;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    gcnt_d  = gcnt_q;
    sh_d    = sh_q;
    par_d   = par_q;
    chk_d   = chk_q;
    nack_d  = nack_q;
    case (state_q)
      F_START: begin
        if (etu_tick) begin
          state_d = F_DATA;
          cnt_d   = '0;
        end
      end
      F_DATA: begin
        if (etu_tick) begin
          sh_d = sh_q >> 1;
          if (cnt_q == LAST_BIT) state_d = F_PAR;
          else                   cnt_d   = cnt_q + 1'b1;
        end
      end
      F_PAR: begin
        if (etu_tick) begin
          state_d = F_GUARD;
          gcnt_d  = '0;
        end
      end
      F_GUARD: begin
        if (etu_tick) begin
          if (gcnt_q == SAMP_AT) nack_d = chk_q & ~line_in;
          if (gcnt_q == GRD_LAST) state_d = F_IDLE;
          else                    gcnt_d  = gcnt_q + 1'b1;
        end
      end
      default: ;
    endcase
    if (load) begin
      state_d = F_START;
      sh_d    = start_msb ? data_rev : start_data;
      par_d   = ^start_data;
      chk_d   = start_chk;
      nack_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= F_IDLE;
      cnt_q   <= '0;
      gcnt_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      chk_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else if (en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gcnt_q  <= gcnt_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      chk_q   <= chk_d;
      nack_q  <= nack_d;
    end
  end

  assign line_drive_low = (state_q == F_START)
                        | ((state_q == F_DATA) & ~sh_q[0])
                        | ((state_q == F_PAR)  & ~par_q);
  assign frame_idle     = (state_q == F_IDLE);
  assign nack           = nack_q;

endmodule

// File: rtl/sc_tx_retry.sv
module sc_tx_retry
  import sc_tx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int RETRY_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic [1:0]           mode,
  input  logic [RETRY_W-1:0]   retry_limit,
  input  logic                 msb_first,
  input  logic                 frame_idle,
  input  logic                 attempt_end,
  input  logic                 nack,
  output logic                 tx_ready,
  output logic                 start,
  output logic [DATA_BITS-1:0] start_data,
  output logic                 start_msb,
  output logic                 start_chk,
  output logic                 done,
  output logic                 err_flag
);

  sc_mode_e             mode_e;
  logic                 accept;
  logic                 retry_go;
  logic                 fin;
  logic                 chk_now;
  logic                 byte_now;

  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 msb_q, msb_d;
  logic                 chk_q, chk_d;
  logic                 byte_q, byte_d;
  logic [RETRY_W-1:0]   left_q, left_d;
  logic                 done_q, done_d;
  logic                 err_q, err_d;
  logic                 cfg_en;
  logic                 left_en;

  assign mode_e   = sc_mode_e'(mode);
  assign tx_ready = rst_n & frame_idle & (mode_e != MODE_RSVD);
  assign accept   = tx_valid & tx_ready;
  assign chk_now  = (mode_e == MODE_BYTE) | (mode_e == MODE_BLOCK);
  assign byte_now = (mode_e == MODE_BYTE);

  assign retry_go = attempt_end & nack & byte_q & (left_q != '0);
  assign fin      = attempt_end & ~retry_go;

  assign start      = accept | retry_go;
  assign start_data = accept ? tx_data   : data_q;
  assign start_msb  = accept ? msb_first : msb_q;
  assign start_chk  = accept ? chk_now   : chk_q;

  assign cfg_en  = accept;
  assign left_en = accept | retry_go;

  always_comb begin
    data_d = tx_data;
    msb_d  = msb_first;
    chk_d  = chk_now;
    byte_d = byte_now;
    left_d = accept ? retry_limit : (left_q - 1'b1);
    done_d = fin;
    err_d  = err_q;
    if (accept)   err_d = 1'b0;
    else if (fin) err_d = nack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      msb_q  <= 1'b0;
      chk_q  <= 1'b0;
      byte_q <= 1'b0;
    end else if (cfg_en) begin
      data_q <= data_d;
      msb_q  <= msb_d;
      chk_q  <= chk_d;
      byte_q <= byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign done     = done_q;
  assign err_flag = err_q;

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int DATA_BITS   = 8,
  parameter int RETRY_W     = 3,
  parameter int GUARD_ETU   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 tx_ready,
  input  logic [1:0]           mode,
  input  logic [RETRY_W-1:0]   retry_limit,
  input  logic                 msb_first,
  input  logic                 etu_tick,
  input  logic                 io_in,
  output logic                 io_drive_low,
  output logic                 done,
  output logic                 err_flag
);

  logic                 rst_int_n;
  logic                 line_s;
  logic                 frame_idle;
  logic                 attempt_end;
  logic                 nack;
  logic                 start;
  logic [DATA_BITS-1:0] start_data;
  logic                 start_msb;
  logic                 start_chk;

  // reset: asserted at once, released after a short synchroniser
  sc_tx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  sc_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (io_in),
    .q     (line_s)
  );

  sc_tx_frame #(.DATA_BITS(DATA_BITS), .GUARD_ETU(GUARD_ETU)) u_frame (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .etu_tick       (etu_tick),
    .start          (start),
    .start_data     (start_data),
    .start_msb      (start_msb),
    .start_chk      (start_chk),
    .line_in        (line_s),
    .line_drive_low (io_drive_low),
    .frame_idle     (frame_idle),
    .attempt_end    (attempt_end),
    .nack           (nack)
  );

  sc_tx_retry #(.DATA_BITS(DATA_BITS), .RETRY_W(RETRY_W)) u_retry (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .mode        (mode),
    .retry_limit (retry_limit),
    .msb_first   (msb_first),
    .frame_idle  (frame_idle),
    .attempt_end (attempt_end),
    .nack        (nack),
    .tx_ready    (tx_ready),
    .start       (start),
    .start_data  (start_data),
    .start_msb   (start_msb),
    .start_chk   (start_chk),
    .done        (done),
    .err_flag    (err_flag)
  );

endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [1:0] mode,
  input logic       io_drive_low,
  input logic       done,
  input logic       err_flag
);

  p_rsvd_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !tx_ready);

  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !io_drive_low);

  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> io_drive_low);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !err_flag);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(tx_valid && tx_ready)) |=> err_flag);

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> done);

  p_done_frees_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode != 2'b11) |-> tx_ready);

endmodule

bind sc_char_tx sc_char_tx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .mode         (mode),
  .io_drive_low (io_drive_low),
  .done         (done),
  .err_flag     (err_flag)
);

// File: tb/sim_sc_char_tx.sv
`timescale 1ns/1ps
module sim_sc_char_tx;

  localparam int ETU = 8;
  localparam int NV  = 8;

  logic       clk;
  logic       rst_n;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready;
  logic [1:0] mode;
  logic [2:0] retry_limit;
  logic       msb_first;
  logic       etu_tick;
  logic       io_in;
  logic       io_drive_low;
  logic       done;
  logic       err_flag;
  logic       card_nack;

  int checks;
  int fails;
  bit finished;

  // {mode, retry, msb, data, nack per attempt, attempts, error}
  localparam logic [26:0] VECS [NV] = '{
    {2'b01, 3'd0, 1'b0, 8'hA5, 8'h00, 4'd1, 1'b0},
    {2'b01, 3'd3, 1'b1, 8'h3C, 8'h03, 4'd3, 1'b0},
    {2'b01, 3'd2, 1'b0, 8'h81, 8'hFF, 4'd3, 1'b1},
    {2'b01, 3'd0, 1'b1, 8'h7E, 8'h01, 4'd1, 1'b1},
    {2'b10, 3'd7, 1'b0, 8'h5A, 8'h01, 4'd1, 1'b1},
    {2'b00, 3'd5, 1'b0, 8'hFF, 8'h01, 4'd1, 1'b0},
    {2'b01, 3'd7, 1'b1, 8'h00, 8'hFF, 4'd8, 1'b1},
    {2'b01, 3'd1, 1'b0, 8'hC3, 8'h01, 4'd2, 1'b0}
  };

  assign io_in = ~(io_drive_low | card_nack);

  sc_char_tx u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_ready     (tx_ready),
    .mode         (mode),
    .retry_limit  (retry_limit),
    .msb_first    (msb_first),
    .etu_tick     (etu_tick),
    .io_in        (io_in),
    .io_drive_low (io_drive_low),
    .done         (done),
    .err_flag     (err_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] exp_pat(input logic [7:0] d, input logic m);
    logic [11:0] p;
    p = '0;
    p[0] = 1'b1;
    for (int k = 0; k < 8; k++) p[k+1] = ~(m ? d[7-k] : d[k]);
    p[9] = ~(^d);
    return p;
  endfunction

  // one 12-etu attempt; returns drive level seen mid-etu
  task automatic run_attempt(input logic [7:0] d, input bit nack_this,
                             input bit first, output logic [11:0] seen);
    for (int e = 0; e < 12; e++) begin
      if (e == 10) card_nack = nack_this;
      if (first && e == 1) begin
        tx_valid = 1'b1;
        tx_data  = ~d;
      end
      repeat (ETU - 1) @(negedge clk);
      seen[e] = io_drive_low;
      if (first && e == 1)
        check(tx_ready == 1'b0, "R1 ready low while busy", 32'(tx_ready), 0);
      if (first && e == 9) tx_valid = 1'b0;
      etu_tick = 1'b1;
      @(negedge clk);
      etu_tick = 1'b0;
      if (e == 10) card_nack = 1'b0;
    end
  endtask

  initial begin
    logic [11:0] seen;
    logic [26:0] v;
    logic [7:0]  d;
    logic        m;
    int          na;
    bit          bad;
    checks = 0; fails = 0; finished = 0;
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = '0; mode = 2'b01;
    retry_limit = '0; msb_first = 1'b0; etu_tick = 1'b0; card_nack = 1'b0;

    repeat (3) @(negedge clk);
    check(io_drive_low == 1'b0, "R9 line in reset", 32'(io_drive_low), 0);
    check(done == 1'b0 && err_flag == 1'b0, "R9 done/err in reset",
          {30'b0, done, err_flag}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(tx_ready == 1'b1, "R9 ready after reset", 32'(tx_ready), 1);
    check(io_drive_low == 1'b0 && done == 1'b0 && err_flag == 1'b0,
          "R9 outputs after reset", {29'b0, io_drive_low, done, err_flag}, 0);

    // reserved mode: offered byte must be ignored
    mode = 2'b11; tx_valid = 1'b1; tx_data = 8'h00;
    bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_ready || io_drive_low) bad = 1'b1;
    end
    tx_valid = 1'b0; mode = 2'b01;
    @(negedge clk);
    check(!bad, "R1 reserved mode ignores tx_valid", 32'(bad), 0);
    check(tx_ready == 1'b1 && io_drive_low == 1'b0, "R1 idle after reserved",
          {30'b0, tx_ready, io_drive_low}, 2);

    for (int vi = 0; vi < NV; vi++) begin
      v = VECS[vi];
      d = v[20:13];
      m = v[21];
      mode = v[26:25]; retry_limit = v[24:22]; msb_first = m; tx_data = d;
      @(negedge clk);
      check(tx_ready == 1'b1, "R1 ready before accept", 32'(tx_ready), 1);
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      check(err_flag == 1'b0, "R8 err cleared by accept", 32'(err_flag), 0);
      // settings change mid-character must not matter
      mode        = (v[26:25] == 2'b01) ? 2'b10 : 2'b01;
      retry_limit = ~v[24:22];
      msb_first   = ~m;
      na = int'(v[4:1]);
      for (int a = 0; a < na; a++) begin
        run_attempt(d, v[5 + a], a == 0, seen);
        check(seen == exp_pat(d, m), "R2 R3 frame pattern", 32'(seen),
              32'(exp_pat(d, m)));
        check(done == (a == na - 1), "R5 R6 R7 done after attempt",
              32'(done), 32'(a == na - 1));
        if (a == na - 1)
          check(err_flag == v[0], "R4 R5 R6 R7 R8 error at end",
                32'(err_flag), 32'(v[0]));
      end
      repeat (6) @(negedge clk);
      check(done == 1'b0 && io_drive_low == 1'b0, "R5 R8 no further attempt",
            {30'b0, done, io_drive_low}, 0);
      check(err_flag == v[0], "R8 err sticky", 32'(err_flag), 32'(v[0]));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule